// File: doc/BRIEF.md
# Delayed One-Shot Pulse Generator

This block emits a single pulse of programmable width a programmable time after a start request. Two chained down-counting channels do the work. The first channel (the delay counter) loads its own value when a start is accepted and counts it out. Its completion strobe then starts the second channel (the width counter), which loads its own value and holds the pulse output active until it reaches zero. All counting advances only on cycles where the count-clock enable is high, so a prescaler outside the block sets the time base.

A start comes from one of two sources. The first is an edge on an asynchronous trigger pin, which is synchronized by a two-flop chain and edge-detected with a selectable polarity. The second is a one-cycle software strobe. Starts that arrive while a shot is in progress are dropped. Each channel samples its data input only at its own load moment. Software may therefore rewrite the delay value once the delay channel has finished, and the width value once the width channel has finished, without disturbing the current shot.

Top module: `dly_oneshot`

## Requirements
- R1: After reset the pulse output is at its inactive level, both completion strobes are low and `busy` is low.
- R2: Count ticks are cycles with `cnt_en` high, and the tick that loads the delay counter is tick 1. `master_done` is high for exactly one clock cycle, in the cycle that follows tick D+1, where D is the delay value.
- R3: The pulse output becomes active in the cycle that follows tick D+2. That is one tick after `master_done`, giving a delay of D+2 ticks.
- R4: With width value W greater than zero, the pulse stays active for exactly W ticks. It returns to inactive in the cycle that follows tick D+2+W, and `slave_done` is high for one cycle in that same cycle.
- R5: A width value of zero produces no active level at all, and `slave_done` is still issued after tick D+2.
- R6: A high `sw_start` for one cycle starts a shot with the same tick timing as a detected pin edge.
- R7: With `edge_sel` 0 a rising edge on `trig_in` starts a shot, and with `edge_sel` 1 a falling edge does. The opposite edge is ignored. The pin passes two synchronizer flops and one history flop, so a pin change made just after clock edge 0 is accepted at clock edge 3.
- R8: With `out_pol` 1 the active level of `pulse_out` is high. With `out_pol` 0 it is low, and the idle level is the inverse.
- R9: A start request that arrives while `busy` is high is ignored. It produces no second `master_done` and no second pulse.
- R10: `busy` is high from the cycle after a start is accepted until the `slave_done` cycle, and it is low in that cycle.
- R11: The delay counter captures `delay_val` only when it loads, and the width counter captures `width_val` only when it loads. Changes made while the respective counter runs do not alter the current shot.
- R12: Neither counter changes on cycles with `cnt_en` low, so all timings scale with the enable rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_en | input | 1 | Count-clock enable, one tick per high cycle |
| trig_in | input | 1 | Asynchronous trigger pin |
| edge_sel | input | 1 | 0 = rising edge starts, 1 = falling edge starts |
| sw_start | input | 1 | Software start strobe |
| delay_val | input | CNT_W | Delay counter reload value |
| width_val | input | CNT_W | Width counter reload value |
| out_pol | input | 1 | Active level of the pulse output |
| pulse_out | output | 1 | Delayed pulse |
| master_done | output | 1 | One-cycle strobe when the delay counter reaches zero |
| slave_done | output | 1 | One-cycle strobe when the width counter reaches zero |
| busy | output | 1 | Shot in progress |

## Verification
The hardest situation to reach is a second start, or a data rewrite, that lands in the middle of a shot. This has to happen while the delay counter is still counting, and the width rewrite has to happen while the pulse is already active. The per-shot task counts enable ticks from the accepting clock edge. At chosen tick numbers it fires another software strobe, rewrites the delay value and later rewrites the width value. It then checks that the strobe ticks and the pulse edges still match the original values. The same task runs with a one-in-three enable pattern, so that a counter that ignores the enable is exposed.

// File: rtl/dly_oneshot_pkg.sv
package dly_oneshot_pkg;

    localparam int unsigned CNT_W_DEFAULT = 16;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_mode_e;

endpackage

// File: rtl/dly_oneshot_edge.sv
module dly_oneshot_edge
    import dly_oneshot_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin,
    input  edge_mode_e mode,
    output logic       evt
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              hist;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic        cur;

    assign cur = st_q.sync[STAGES-1];

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin};
        st_d.hist = cur;
        if (mode == EDGE_FALL) begin
            evt = st_q.hist & ~cur;
        end else begin
            evt = cur & ~st_q.hist;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/dly_oneshot_chan.sv
module dly_oneshot_chan #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             pending,
    output logic             running,
    output logic             done
);

    typedef struct packed {
        logic             pend;
        logic             run;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic        go;

    assign go = start | st_q.pend;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (tick) begin
            if (go) begin
                st_d.pend = 1'b0;
                st_d.cnt  = load_val;
                if (load_val == '0) begin
                    st_d.run  = 1'b0;
                    st_d.done = 1'b1;
                end else begin
                    st_d.run = 1'b1;
                end
            end else if (st_q.run) begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
                if (st_q.cnt == CNT_W'(1)) begin
                    st_d.run  = 1'b0;
                    st_d.done = 1'b1;
                end
            end
        end else if (start) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pend;
    assign running = st_q.run;
    assign done    = st_q.done;

endmodule

// File: rtl/dly_oneshot.sv
module dly_oneshot
    import dly_oneshot_pkg::*;
#(
    parameter int unsigned CNT_W       = CNT_W_DEFAULT,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             trig_in,
    input  logic             edge_sel,
    input  logic             sw_start,
    input  logic [CNT_W-1:0] delay_val,
    input  logic [CNT_W-1:0] width_val,
    input  logic             out_pol,
    output logic             pulse_out,
    output logic             master_done,
    output logic             slave_done,
    output logic             busy
);

    logic pin_evt;
    logic accept;
    logic m_pend, m_run, m_done;
    logic s_pend, s_run, s_done;

    dly_oneshot_edge #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (trig_in),
        .mode  (edge_mode_e'(edge_sel)),
        .evt   (pin_evt)
    );

    assign busy   = m_pend | m_run | m_done | s_pend | s_run;
    assign accept = (pin_evt | sw_start) & ~busy;

    dly_oneshot_chan #(
        .CNT_W (CNT_W)
    ) u_delay_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cnt_en),
        .start    (accept),
        .load_val (delay_val),
        .pending  (m_pend),
        .running  (m_run),
        .done     (m_done)
    );

    dly_oneshot_chan #(
        .CNT_W (CNT_W)
    ) u_width_ch (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cnt_en),
        .start    (m_done),
        .load_val (width_val),
        .pending  (s_pend),
        .running  (s_run),
        .done     (s_done)
    );

    assign pulse_out   = s_run ? out_pol : ~out_pol;
    assign master_done = m_done;
    assign slave_done  = s_done;

endmodule

// File: rtl/dly_oneshot_chk.sv
module dly_oneshot_chk (
    input logic clk,
    input logic rst_n,
    input logic cnt_en,
    input logic out_pol,
    input logic pulse_out,
    input logic master_done,
    input logic slave_done,
    input logic busy
);

    logic act;
    assign act = (pulse_out == out_pol);

    a_r10_active_implies_busy: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> busy);

    a_r10_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        slave_done |-> !busy);

    a_r2_mdone_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        master_done |=> !master_done);

    a_r4_sdone_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        slave_done |=> !slave_done);

    a_r9_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(master_done && slave_done));

    a_r12_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act) |-> $past(cnt_en));

    a_r4_fall_with_sdone: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act) |-> slave_done);

endmodule

bind dly_oneshot dly_oneshot_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_en      (cnt_en),
    .out_pol     (out_pol),
    .pulse_out   (pulse_out),
    .master_done (master_done),
    .slave_done  (slave_done),
    .busy        (busy)
);

// File: tb/dly_oneshot_bench.sv
`timescale 1ns/1ps
module dly_oneshot_bench;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cnt_en = 1'b1;
    logic          trig_in = 1'b0;
    logic          edge_sel = 1'b0;
    logic          sw_start = 1'b0;
    logic [CW-1:0] delay_val = '0;
    logic [CW-1:0] width_val = '0;
    logic          out_pol = 1'b1;
    logic          pulse_out, master_done, slave_done, busy;

    int n_run = 0;
    int n_fail = 0;
    int div = 1;
    int ph = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (div <= 1) begin
            cnt_en <= 1'b1;
        end else begin
            ph = (ph + 1) % div;
            cnt_en <= (ph == 0);
        end
    end

    dly_oneshot u_dly_oneshot (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnt_en      (cnt_en),
        .trig_in     (trig_in),
        .edge_sel    (edge_sel),
        .sw_start    (sw_start),
        .delay_val   (delay_val),
        .width_val   (width_val),
        .out_pol     (out_pol),
        .pulse_out   (pulse_out),
        .master_done (master_done),
        .slave_done  (slave_done),
        .busy        (busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One shot, timed in enable ticks from the accepting edge.
    task automatic run_shot(input bit use_pin, input int d, input int w,
                            input int dist_m, input int dist_s, input string tag);
        int ticks = 0;
        int lead;
        int m_tick = -1, s_tick = -1, rise_tick = -1, fall_tick = -1;
        int n_m = 0, n_s = 0, n_rise = 0, bad_busy = 0, post = 0;
        bit act_prev = 1'b0;
        bit act;
        bit exp_busy;
        lead = use_pin ? 3 : 1;
        @(negedge clk);
        delay_val = CW'(d);
        width_val = CW'(w);
        if (use_pin) trig_in = (edge_sel == 1'b0);
        else         sw_start = 1'b1;
        for (int k = 1; k <= 400; k++) begin
            @(posedge clk);
            if (k >= lead && cnt_en) ticks++;
            @(negedge clk);
            sw_start = 1'b0;
            if (dist_m > 0 && ticks == dist_m && n_m == 0) begin
                sw_start  = 1'b1;              // R9 retrigger while counting
                delay_val = CW'(d + 5);        // R11 rewrite during delay
            end
            if (dist_s > 0 && ticks == dist_s && n_s == 0) begin
                width_val = CW'(w + 7);        // R11 rewrite during pulse
                sw_start  = 1'b1;
            end
            if (master_done) begin n_m++; m_tick = ticks; end
            if (slave_done)  begin n_s++; s_tick = ticks; end
            act = (pulse_out == out_pol);
            if (act && !act_prev) begin n_rise++; rise_tick = ticks; end
            if (!act && act_prev) fall_tick = ticks;
            act_prev = act;
            exp_busy = (k >= lead) && (n_s == 0);
            if (busy !== exp_busy) bad_busy++;
            if (n_s > 0) begin
                post++;
                if (post > 12) break;
            end
        end
        sw_start = 1'b0;
        check(n_m == 1, {"R2/R9 master_done count ", tag}, n_m, 1);
        check(m_tick == d + 1, {"R2 master_done tick ", tag}, m_tick, d + 1);
        check(n_s == 1, {"R4 slave_done count ", tag}, n_s, 1);
        if (w > 0) begin
            check(rise_tick == d + 2, {"R3 active tick ", tag}, rise_tick, d + 2);
            check(fall_tick == d + 2 + w, {"R4 inactive tick ", tag}, fall_tick, d + 2 + w);
            check(s_tick == d + 2 + w, {"R4 slave_done tick ", tag}, s_tick, d + 2 + w);
            check(n_rise == 1, {"R9 pulse count ", tag}, n_rise, 1);
        end else begin
            check(n_rise == 0, {"R5 no pulse ", tag}, n_rise, 0);
            check(s_tick == d + 2, {"R5 slave_done tick ", tag}, s_tick, d + 2);
        end
        check(bad_busy == 0, {"R10 busy window ", tag}, bad_busy, 0);
        if (use_pin) trig_in = edge_sel;
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(pulse_out == ~out_pol, "R1 pulse idle", pulse_out, ~out_pol);
        check(!master_done && !slave_done, "R1 strobes low", master_done + slave_done, 0);
        check(!busy, "R1 busy low", busy, 0);
    endtask

    task automatic t_sw_basic();
        run_shot(1'b0, 4, 3, 0, 0, "R6 sw d4 w3");
    endtask

    task automatic t_pin_rise();
        edge_sel = 1'b0;
        run_shot(1'b1, 2, 5, 0, 0, "R7 rise d2 w5");
    endtask

    task automatic t_zero_width();
        run_shot(1'b0, 3, 0, 0, 0, "R5 w0");
    endtask

    task automatic t_min_delay();
        run_shot(1'b0, 0, 1, 0, 0, "R3 d0 w1");
    endtask

    task automatic t_slow_tick();
        div = 3;
        repeat (4) @(negedge clk);
        run_shot(1'b0, 3, 4, 0, 0, "R12 div3");
        div = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_low_pol();
        @(negedge clk);
        out_pol = 1'b0;
        @(negedge clk);
        check(pulse_out == 1'b1, "R8 idle high when active-low", pulse_out, 1);
        run_shot(1'b0, 2, 3, 0, 0, "R8 pol0");
        out_pol = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_disturb();
        run_shot(1'b0, 6, 4, 3, 6 + 3, "R9/R11 disturb");
    endtask

    task automatic t_pin_fall();
        int seen = 0;
        @(negedge clk);
        edge_sel = 1'b1;
        trig_in  = 1'b1;
        repeat (8) begin
            @(negedge clk);
            if (master_done || busy) seen++;
        end
        check(seen == 0, "R7 rising ignored in falling mode", seen, 0);
        run_shot(1'b1, 1, 2, 0, 0, "R7 fall d1 w2");
        edge_sel = 1'b0;
        trig_in  = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_sw_basic();
        t_pin_rise();
        t_zero_width();
        t_min_delay();
        t_slow_tick();
        t_low_pol();
        t_disturb();
        t_pin_fall();
        finished = 1'b1;
        summary();
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            summary();
        end
    end

endmodule